// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a core-side request port and a memory port that moves whole 64-byte lines. Each request address is divided into a tag, a set index and a byte offset within the line. All ways of the addressed set are compared in the same cycle. A read hit returns its word on the next cycle. A write hit changes only the cached copy and marks the line dirty.

On a miss the controller picks a victim way. An invalid way is always taken first. Once the set is full, the victim is chosen at random from every way except the most recently used one. A dirty victim is written back to memory before the new line is fetched. Write misses allocate: the line is fetched and the write is merged into it.

Each stored line carries one parity bit. A parity failure on a clean line is handled quietly as a miss, and the line is fetched again. A parity failure on a dirty line produces an error response and no data. Only one miss is handled at a time, and the core port is held not-ready while memory traffic is in progress.

Top module: `wbcache_top`

## Requirements
- R1: With the default parameters, address bits [31:9] are the tag, bits [8:6] select one of 8 sets, bits [5:2] select one of 16 32-bit words in the line, and bits [1:0] are ignored.
- R2: A read hit raises resp_valid on the cycle after the request is accepted, returns the addressed word, and starts no memory transaction.
- R3: A write hit updates only the cached word and marks the line dirty. No memory transaction follows, and a later read returns the new value.
- R4: A write miss fetches the line, merges the written word into it and then responds. The other words of the line keep their memory values.
- R5: A dirty victim is written to memory at its own line address, and the whole current line is written, before the fill starts. A clean victim causes no memory write.
- R6: While a set still holds an invalid way, a miss fills an invalid way and no valid line is evicted.
- R7: When all ways of a set are valid, the victim is never the way that was most recently hit or filled in that set.
- R8: The stored parity bit makes the XOR of the line and its parity bit zero. At fill time it is taken from mem_rpar. A write updates it incrementally from the old and new word. Lines with good parity never give an error.
- R9: A hit on a clean line whose parity fails is handled as a miss. The line is fetched again into the same way, and the correct data is returned.
- R10: A hit on a dirty line whose parity fails answers with resp_err=1 and resp_rdata=0. It leaves the line unchanged and makes no memory request.
- R11: req_ready is low for the whole time a write-back or fill is in progress, and only one miss is handled at a time.
- R12: After reset, req_ready is 1, resp_valid and mem_req are 0, and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted when high together with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 32 | Read word (0 for writes and errors) |
| resp_err | output | 1 | Uncorrectable parity failure on a dirty line |
| mem_req | output | 1 | Memory transaction in progress |
| mem_we | output | 1 | 1 for a line write-back, 0 for a line fetch |
| mem_addr | output | 26 | Line address (byte address divided by 64) |
| mem_wdata | output | 512 | Line being written back |
| mem_ready | input | 1 | Memory completes the current transaction this cycle |
| mem_rdata | input | 512 | Fetched line, valid with mem_ready |
| mem_rpar | input | 1 | Parity bit of the fetched line |

## Verification
Two cases can coincide in one miss. A write can miss into a full set whose chosen victim is dirty. A line fetched with a corrupted parity bit can also receive a write merge in the same fill cycle. The bench provokes the first by writing a line, then missing on fresh tags in that set until a write-back appears. Each write-back must carry the latest golden data at the victim's address. It provokes the second by corrupting mem_rpar on a write-allocate fill. The next access to that dirty line must return an error with zero data and cause no memory traffic. A corrupted fill on a clean line is judged separately: it must lead to exactly one extra fetch and then to clean hits.

// File: rtl/wbcache_pkg.sv
package wbcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cache_state_t;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter int          WIDTH = 8,
  parameter logic [7:0]  TAPS  = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ WIDTH'(TAPS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WIDTH'(1);
    else        state_q <= state_d;
  end

  assign value = state_q;

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_val,
  input  logic [WAY_W-1:0] mru,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] victim
);
  logic             found;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    found    = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_val[w] && !found) begin
        found    = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    if (found)          victim = free_way;
    else if (rnd == mru) victim = rnd + WAY_W'(1);
    else                 victim = rnd;
  end
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 23,
  parameter int LINE_W = 512,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0]             way_val,
  input  logic [WAYS-1:0][LINE_W-1:0] way_line,
  input  logic [WAYS-1:0]             way_par,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        hit_pbad
);
  logic [WAYS-1:0] match, pbad;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = way_val[w] && (way_tag[w] == look_tag);
    assign pbad[w]  = ^{way_line[w], way_par[w]};
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign hit      = |match;
  assign hit_pbad = pbad[hit_way];

  assert_single_match_R6: assert final ($onehot0(match));
endmodule

// File: rtl/wbcache_top.sv
module wbcache_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 512,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int RND_W  = 8,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int BOFF_W = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_W / DATA_W),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int IDX_W  = SET_W + WAY_W,
  localparam int NLINES = SETS * WAYS,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_rpar
);
  import wbcache_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_s, rst_meta} <= 2'b00;
    else        {rst_n_s, rst_meta} <= {rst_meta, 1'b1};
  end

  // storage
  logic [LINE_W-1:0] line_q [NLINES];
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [WAY_W-1:0]  mru_q  [SETS];
  logic [NLINES-1:0] val_q, dirty_q, par_q;

  cache_state_t      st_q, st_d;
  logic [SET_W-1:0]  m_set;
  logic [TAG_W-1:0]  m_tag, m_vtag;
  logic [WAY_W-1:0]  m_way;
  logic [WORD_W-1:0] m_word;
  logic              m_write;
  logic [DATA_W-1:0] m_wdata;
  logic              rsp_v_q, rsp_e_q;
  logic [DATA_W-1:0] rsp_d_q;

  // request fields
  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WORD_W-1:0] req_word;
  logic              unused_low_bits;
  assign req_set  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_word = req_addr[BOFF_W +: WORD_W];
  assign unused_low_bits = ^req_addr[BOFF_W-1:0];

  // view of the addressed set
  logic [WAYS-1:0][TAG_W-1:0]  v_tag;
  logic [WAYS-1:0][LINE_W-1:0] v_line;
  logic [WAYS-1:0]             v_val, v_dirty, v_par;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      v_tag[w]   = tag_q[{req_set, WAY_W'(w)}];
      v_line[w]  = line_q[{req_set, WAY_W'(w)}];
      v_val[w]   = val_q[{req_set, WAY_W'(w)}];
      v_dirty[w] = dirty_q[{req_set, WAY_W'(w)}];
      v_par[w]   = par_q[{req_set, WAY_W'(w)}];
    end
  end

  logic             hit, hit_pbad;
  logic [WAY_W-1:0] hit_way, victim;
  logic [RND_W-1:0] rnd;

  cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_lookup (
    .way_tag(v_tag), .way_val(v_val), .way_line(v_line), .way_par(v_par),
    .look_tag(req_tag), .hit(hit), .hit_way(hit_way), .hit_pbad(hit_pbad));

  cache_lfsr #(.WIDTH(RND_W)) u_lfsr (.clk(clk), .rst_n(rst_n_s), .value(rnd));

  cache_victim #(.WAYS(WAYS)) u_victim (
    .way_val(v_val), .mru(mru_q[req_set]), .rnd(rnd[WAY_W-1:0]), .victim(victim));

  // next-state and write control
  logic              accept, cap_en;
  logic [WAY_W-1:0]  cap_way;
  logic              wr_en, wr_par, wr_dirty;
  logic [IDX_W-1:0]  wr_idx;
  logic [LINE_W-1:0] wr_line, base_line;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] old_w, new_w;
  logic              rsp_v_d, rsp_e_d;
  logic [DATA_W-1:0] rsp_d_d;

  assign accept = req_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q; cap_en = 1'b0; cap_way = victim;
    wr_en = 1'b0; wr_idx = {req_set, hit_way}; wr_tag = req_tag;
    wr_dirty = 1'b1; base_line = v_line[hit_way];
    rsp_v_d = 1'b0; rsp_e_d = 1'b0; rsp_d_d = '0;
    old_w = base_line[req_word*DATA_W +: DATA_W];
    new_w = req_wdata; wr_line = base_line; wr_par = v_par[hit_way];
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (hit && !hit_pbad) begin
          rsp_v_d = 1'b1;
          if (req_write) begin
            wr_en = 1'b1;
            wr_line[req_word*DATA_W +: DATA_W] = new_w;
            wr_par   = v_par[hit_way] ^ (^old_w) ^ (^new_w);
            wr_dirty = 1'b1;
          end else begin
            rsp_d_d = old_w;
          end
        end else if (hit && v_dirty[hit_way]) begin
          rsp_v_d = 1'b1;
          rsp_e_d = 1'b1;
        end else begin
          cap_en  = 1'b1;
          cap_way = hit ? hit_way : victim;
          st_d = (!hit && v_val[victim] && v_dirty[victim]) ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: if (mem_ready) st_d = ST_FILL;
      ST_FILL: if (mem_ready) begin
        wr_en     = 1'b1;
        wr_idx    = {m_set, m_way};
        wr_tag    = m_tag;
        wr_dirty  = m_write;
        base_line = mem_rdata;
        old_w     = mem_rdata[m_word*DATA_W +: DATA_W];
        new_w     = m_wdata;
        wr_line   = mem_rdata;
        wr_par    = mem_rpar;
        if (m_write) begin
          wr_line[m_word*DATA_W +: DATA_W] = m_wdata;
          wr_par = mem_rpar ^ (^old_w) ^ (^m_wdata);
        end else begin
          rsp_d_d = old_w;
        end
        rsp_v_d = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= ST_IDLE; val_q <= '0; dirty_q <= '0; par_q <= '0;
      rsp_v_q <= 1'b0; rsp_e_q <= 1'b0; rsp_d_q <= '0;
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else begin
      st_q <= st_d; rsp_v_q <= rsp_v_d; rsp_e_q <= rsp_e_d; rsp_d_q <= rsp_d_d;
      if (wr_en) begin
        val_q[wr_idx]   <= 1'b1;
        dirty_q[wr_idx] <= wr_dirty;
        par_q[wr_idx]   <= wr_par;
        mru_q[wr_idx[IDX_W-1 -: SET_W]] <= wr_idx[WAY_W-1:0];
      end else if (accept && hit && !hit_pbad) begin
        mru_q[req_set] <= hit_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[wr_idx] <= wr_line;
      tag_q[wr_idx]  <= wr_tag;
    end
    if (cap_en) begin
      m_set <= req_set; m_tag <= req_tag; m_vtag <= v_tag[cap_way];
      m_way <= cap_way; m_word <= req_word; m_write <= req_write;
      m_wdata <= req_wdata;
    end
  end

  // outputs
  assign req_ready  = (st_q == ST_IDLE) && rst_n_s;
  assign resp_valid = rsp_v_q;
  assign resp_err   = rsp_e_q;
  assign resp_rdata = rsp_d_q;
  assign mem_req    = (st_q != ST_IDLE);
  assign mem_we     = (st_q == ST_WBACK);
  assign mem_addr   = (st_q == ST_WBACK) ? {m_vtag, m_set} : {m_tag, m_set};
  assign mem_wdata  = line_q[{m_set, m_way}];

  // checks
  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req |-> !req_ready);
  assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && hit && !hit_pbad) |=> (resp_valid && !resp_err && !mem_req));
  assert_invalid_first_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !hit && !(&v_val)) |-> !v_val[victim]);
  assert_not_mru_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !hit && (&v_val)) |-> (victim != mru_q[req_set]));
  assert_err_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    resp_err |-> (resp_valid && resp_rdata == '0));
  assert_fill_done_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_FILL && mem_ready) |=> (resp_valid && req_ready));
endmodule

// File: tb/tb_wbcache_top.sv
module tb_wbcache_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr, req_wdata;
  logic         resp_valid, resp_err;
  logic [31:0]  resp_rdata;
  logic         mem_req, mem_we, mem_ready, mem_rpar;
  logic [25:0]  mem_addr;
  logic [511:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  wbcache_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar));

  int tests = 0, fails = 0;
  int fills = 0, wbs = 0;
  bit inject = 1'b0, ready_viol = 1'b0;
  logic [25:0] last_wb;
  logic [511:0] mline [logic [25:0]];
  logic [31:0]  gold  [logic [31:0]];

  function automatic logic [31:0] mk(int tag, int set, int word);
    return {23'(tag), 3'(set), 4'(word), 2'b00};
  endfunction
  function automatic logic [31:0] init_w(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction
  function automatic logic [511:0] get_line(logic [25:0] la);
    logic [511:0] l;
    if (mline.exists(la)) return mline[la];
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = init_w({la, 4'(i), 2'b00});
    return l;
  endfunction
  function automatic logic [31:0] gold_w(logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    return gold.exists(k) ? gold[k] : init_w(k);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // memory model: completes each transaction after a short latency
  initial begin
    int cnt = 0;
    mem_ready = 1'b0; mem_rdata = '0; mem_rpar = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (req_ready) ready_viol = 1'b1;
        cnt++;
        if (cnt >= 3) begin
          if (mem_we) begin
            bit same = 1'b1;
            for (int i = 0; i < 16; i++)
              if (mem_wdata[i*32 +: 32] != gold_w({mem_addr, 4'(i), 2'b00})) same = 1'b0;
            chk(same, "R5 writeback data", mem_wdata[63:0], 64'(get_line(mem_addr)));
            mline[mem_addr] = mem_wdata; last_wb = mem_addr; wbs++;
          end else begin
            mem_rdata = get_line(mem_addr);
            mem_rpar  = (^mem_rdata) ^ inject;
            inject = 1'b0; fills++;
          end
          mem_ready = 1'b1;
        end
      end
    end
  end

  task automatic op(input bit wr, input logic [31:0] a, input logic [31:0] d,
                    input bit upd, output logic [31:0] rd, output bit er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata; er = resp_err;
    if (wr && upd) gold[{a[31:2], 2'b00}] = d;
  endtask

  task automatic rd_chk(input logic [31:0] a, input string req);
    logic [31:0] rd; bit er;
    op(1'b0, a, 32'h0, 1'b0, rd, er);
    chk(rd == gold_w(a) && !er, req, {31'h0, er, rd}, {32'h0, gold_w(a)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    tests++; fails++;
    finish_run();
  end

  initial begin
    logic [31:0] rd; bit er; int f0, w0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R12 reset state",
        {req_ready, resp_valid, mem_req}, 3'b100);

    // R6 / R12: four tags fill the invalid ways of set 0, then all hit
    for (int t = 1; t <= 4; t++) rd_chk(mk(t, 0, t), "R6 fill data");
    chk(fills == 4 && wbs == 0, "R12 R6 fills from empty", fills, 4);
    for (int t = 1; t <= 4; t++) rd_chk(mk(t, 0, 0), "R2 hit data");
    chk(fills == 4, "R6 no valid way evicted early", fills, 4);

    // R7: the most recently used line survives a conflicting miss
    for (int i = 0; i < 8; i++) begin
      int keep = (i == 0) ? 1 : 9 + i;
      rd_chk(mk(keep, 0, 5), "R7 touch");
      rd_chk(mk(10 + i, 0, 1), "R7 miss data");
      f0 = fills;
      rd_chk(mk(keep, 0, 6), "R7 mru data");
      chk(fills == f0, "R7 mru line kept", fills, f0);
    end
    chk(wbs == 0, "R5 clean victims not written", wbs, 0);

    // R3: write hit stays in cache
    rd_chk(mk(1, 1, 0), "R3 setup");
    f0 = fills; w0 = wbs;
    op(1'b1, mk(1, 1, 3), 32'hA5A5_1234, 1'b1, rd, er);
    chk(fills == f0 && wbs == w0 && !er, "R3 write hit no traffic", fills, f0);
    rd_chk(mk(1, 1, 3), "R3 read back");

    // R1: byte offset bits ignored, same word selected
    f0 = fills;
    op(1'b0, mk(1, 1, 3) | 32'h3, 32'h0, 1'b0, rd, er);
    chk(rd == 32'hA5A5_1234 && fills == f0, "R1 low bits ignored", rd, 32'hA5A5_1234);

    // R4: write miss allocates and merges
    f0 = fills;
    op(1'b1, mk(5, 2, 7), 32'h0BAD_F00D, 1'b1, rd, er);
    chk(fills == f0 + 1 && !er, "R4 write miss fills", fills, f0 + 1);
    rd_chk(mk(5, 2, 7), "R4 merged word");
    rd_chk(mk(5, 2, 0), "R4 other word from memory");
    chk(fills == f0 + 1, "R4 line now resident", fills, f0 + 1);

    // R5: evict the dirty line of set 1
    w0 = wbs;
    for (int k = 0; k < 60 && wbs == w0; k++) rd_chk(mk(30 + k, 1, 2), "R5 conflict data");
    chk(wbs == w0 + 1, "R5 dirty victim written back", wbs, w0 + 1);
    chk(last_wb == mk(1, 1, 0) >> 6, "R5 writeback address", last_wb, mk(1, 1, 0) >> 6);
    rd_chk(mk(1, 1, 3), "R5 data survives eviction");

    // R9: clean line with bad parity is fetched again
    f0 = fills; inject = 1'b1;
    rd_chk(mk(9, 3, 4), "R9 first fill data");
    rd_chk(mk(9, 3, 4), "R9 refetch data");
    chk(fills == f0 + 2, "R9 clean parity refetch", fills, f0 + 2);
    rd_chk(mk(9, 3, 4), "R9 clean hit after refetch");
    chk(fills == f0 + 2, "R9 good line hits", fills, f0 + 2);

    // R10 / R8: write-allocate onto bad parity gives a dirty bad line
    inject = 1'b1;
    op(1'b1, mk(9, 7, 2), 32'hDEAD_0001, 1'b1, rd, er);
    chk(!er, "R8 fill merge no error", er, 0);
    f0 = fills; w0 = wbs;
    op(1'b0, mk(9, 7, 2), 32'h0, 1'b0, rd, er);
    chk(er && rd == 0, "R10 dirty parity error", {er, rd}, {1'b1, 32'h0});
    op(1'b1, mk(9, 7, 2), 32'h1111_2222, 1'b0, rd, er);
    chk(er, "R10 write rejected", er, 1);
    op(1'b0, mk(9, 7, 5), 32'h0, 1'b0, rd, er);
    chk(er && rd == 0, "R10 line unchanged", {er, rd}, {1'b1, 32'h0});
    chk(fills == f0 && wbs == w0, "R10 no memory traffic", fills + wbs, f0 + w0);

    // random traffic against the golden model, sets 0..5
    void'($urandom(32'd2024));
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a = mk(20 + ($urandom % 8), $urandom % 6, $urandom % 16);
      if ($urandom % 2) begin
        logic [31:0] d = $urandom;
        op(1'b1, a, d, 1'b1, rd, er);
        chk(!er, "R8 R3 random write no error", er, 0);
      end else begin
        rd_chk(a, "R2 R8 random read");
      end
    end

    chk(!ready_viol, "R11 ready low during memory traffic", ready_viol, 0);
    finish_run();
  end
endmodule